// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

The block is a real-time clock peripheral on a simple 32-bit register bus. A prescaler turns the system clock into a one-second tick, and each tick advances a free-running 32-bit seconds count while counting is switched on. A separate alarm register is compared with the count. Two event flags, one for the per-second step and one for the alarm match, each have their own interrupt enable, and they combine into a single level interrupt.

Software writes only after it sees the write-ready status bit set. Each accepted write is applied to the register in one cycle. Write-ready then reads low for a fixed number of cycles, and a write issued during that window is dropped. Event flags are cleared by writing 0 to their bit. Writing 1 to a flag bit leaves it alone, so a read-modify-write of the control register cannot lose an event. The block also has a hibernate request register that drives an output, and a scratchpad word that software can use to recognise a first power-up.

Top module: `sec_rtc`

## Requirements
- R1: After reset, control (offset 0x00) reads 0x00000080 and seconds, alarm, hibernate and scratchpad read 0. Both `irq` and `hib_req` are 0.
- R2: A write is accepted only when control bit 7 (write-ready) is 1. Bit 7 then reads 0 for exactly WR_BUSY cycles. A write issued while bit 7 is 0 changes no register.
- R3: While control bit 0 (count enable) is 1, the seconds register (offset 0x04) increases by one every PRESCALE clock cycles. While bit 0 is 0, the count holds.
- R4: A write to offset 0x04 loads all 32 bits of the count, and a read returns all 32 bits. The count wraps from 0xFFFFFFFF to 0.
- R5: Control bit 6 (second flag) is set in the cycle after every increment of the count.
- R6: Control bit 4 (alarm flag) is set in the cycle after any cycle in which control bit 2 (alarm enable) is 1 and the count equals the alarm register (offset 0x08).
- R7: A control write with 0 in bit 6 or bit 4 clears that flag. A 1 in either bit leaves that flag unchanged. A set event in the same cycle as a clear wins.
- R8: `irq` is 1 exactly when (bit 6 and bit 5) or (bit 4 and bit 3) of the control register are 1.
- R9: A write to offset 0x20 with bit 0 set raises `hib_req`. `hib_req` stays high until reset, and reads of offset 0x20 return it in bit 0. Writing 0 has no effect.
- R10: The scratchpad at offset 0x34 stores and returns any 32-bit value, and only a write to it changes it.
- R11: Any other offset, including 0x0C, reads 0, and a write to it changes no register or output.
- R12: Control bits 31:8 and bit 1 read 0, and bit 7 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |
| hib_req | output | 1 | Hibernate request |

## Verification
The assertions assume that `bus_wr` and the other bus inputs are stable around the rising edge. They also assume that a flag clear and a tick can meet in the same cycle, and that set-wins then holds. They do not require software to obey write-ready, so the bench issues some writes while busy on purpose to test the drop path. All inputs change only on falling edges. PRESCALE is kept small so that counting, the wrap from the all-ones value and the alarm match all happen within a short run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned OFS_CTRL = 'h00;
   localparam int unsigned OFS_SEC  = 'h04;
   localparam int unsigned OFS_ALRM = 'h08;
   localparam int unsigned OFS_HIB  = 'h20;
   localparam int unsigned OFS_SCR  = 'h34;
   localparam int unsigned B_RDY = 7;
   localparam int unsigned B_F1  = 6;
   localparam int unsigned B_IE1 = 5;
   localparam int unsigned B_AF  = 4;
   localparam int unsigned B_AIE = 3;
   localparam int unsigned B_AE  = 2;
   localparam int unsigned B_EN  = 0;

   typedef struct packed {
      logic ie1;
      logic aie;
      logic ae;
      logic en;
   } ctl_en_t;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
   parameter int unsigned PRESCALE = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (PRESCALE < 1) begin : g_bad_prescale
      $error("PRESCALE must be at least 1");
   end

   if (PRESCALE == 1) begin : g_direct
      assign tick = run;
   end else begin : g_count
      localparam int unsigned CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt_q <= '0;
         else if (!run)          cnt_q <= '0;
         else if (cnt_q == LAST) cnt_q <= '0;
         else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick = run && (cnt_q == LAST);

      // R3
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate #(
   parameter int unsigned WR_BUSY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic accept,
   output logic ready
);
   if (WR_BUSY < 1) begin : g_bad_busy
      $error("WR_BUSY must be at least 1");
   end

   localparam int unsigned CW = $clog2(WR_BUSY + 1);
   logic [CW-1:0] left_q;

   assign ready  = (left_q == '0);
   assign accept = req && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      left_q <= '0;
      else if (accept) left_q <= CW'(WR_BUSY);
      else if (!ready) left_q <= left_q - 1'b1;
   end

   // R2
   busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ready);
   // R2
   no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !accept);
endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hit,
   input  logic ctl_wr,
   input  logic keep_f1,
   input  logic keep_af,
   input  logic ie1,
   input  logic aie,
   output logic f1,
   output logic af,
   output logic irq
);
   logic f1_q, af_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f1_q <= 1'b0;
         af_q <= 1'b0;
      end else begin
         f1_q <= (ctl_wr ? (f1_q & keep_f1) : f1_q) | tick;
         af_q <= (ctl_wr ? (af_q & keep_af) : af_q) | hit;
      end
   end

   assign f1  = f1_q;
   assign af  = af_q;
   assign irq = (f1_q & ie1) | (af_q & aie);

   // R5
   tick_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> f1_q);
   // R6
   hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> af_q);
   // R7
   f1_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(f1_q) |-> $past(ctl_wr && !keep_f1));
   // R7
   af_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(af_q) |-> $past(ctl_wr && !keep_af));
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned PRESCALE = 8,
   parameter int unsigned WR_BUSY  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              hib_req
);
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must cover offset 0x34");
   end

   logic [DATA_W-1:0] sec_q, alarm_q, scr_q;
   logic              hib_q;
   ctl_en_t           ctl_q;
   logic              acc, rdy, tick, hit, f1, af;
   logic              sel_ctrl, sel_sec, sel_alrm, sel_hib, sel_scr;

   assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign sel_sec  = (bus_addr == ADDR_W'(OFS_SEC));
   assign sel_alrm = (bus_addr == ADDR_W'(OFS_ALRM));
   assign sel_hib  = (bus_addr == ADDR_W'(OFS_HIB));
   assign sel_scr  = (bus_addr == ADDR_W'(OFS_SCR));

   rtc_wr_gate #(.WR_BUSY(WR_BUSY)) u_gate (
      .clk(clk), .rst_n(rst_n), .req(bus_wr), .accept(acc), .ready(rdy));

   rtc_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(ctl_q.en), .tick(tick));

   assign hit = ctl_q.ae && (sec_q == alarm_q);

   rtc_event_flags u_flags (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit),
      .ctl_wr(acc && sel_ctrl),
      .keep_f1(bus_wdata[B_F1]), .keep_af(bus_wdata[B_AF]),
      .ie1(ctl_q.ie1), .aie(ctl_q.aie),
      .f1(f1), .af(af), .irq(irq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q   <= '0;
         alarm_q <= '0;
         scr_q   <= '0;
         hib_q   <= 1'b0;
         ctl_q   <= '0;
      end else begin
         if (acc && sel_sec) sec_q <= bus_wdata;
         else if (tick)      sec_q <= sec_q + 1'b1;
         if (acc && sel_alrm) alarm_q <= bus_wdata;
         if (acc && sel_scr)  scr_q   <= bus_wdata;
         if (acc && sel_hib && bus_wdata[0]) hib_q <= 1'b1;
         if (acc && sel_ctrl) begin
            ctl_q.ie1 <= bus_wdata[B_IE1];
            ctl_q.aie <= bus_wdata[B_AIE];
            ctl_q.ae  <= bus_wdata[B_AE];
            ctl_q.en  <= bus_wdata[B_EN];
         end
      end
   end

   assign hib_req = hib_q;

   always_comb begin
      bus_rdata = '0;
      if (sel_ctrl) begin
         bus_rdata[B_RDY] = rdy;
         bus_rdata[B_F1]  = f1;
         bus_rdata[B_IE1] = ctl_q.ie1;
         bus_rdata[B_AF]  = af;
         bus_rdata[B_AIE] = ctl_q.aie;
         bus_rdata[B_AE]  = ctl_q.ae;
         bus_rdata[B_EN]  = ctl_q.en;
      end else if (sel_sec)  bus_rdata = sec_q;
      else if (sel_alrm)     bus_rdata = alarm_q;
      else if (sel_hib)      bus_rdata = {31'd0, hib_q};
      else if (sel_scr)      bus_rdata = scr_q;
   end

   // R4
   sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(acc && sel_sec)) |=> sec_q == $past(sec_q) + 1'b1);
   // R3
   sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q.en && !acc) |=> $stable(sec_q));
   // R2
   busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy |=> ($stable(scr_q) && $stable(alarm_q) && $stable(ctl_q)));
   // R9
   hib_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hib_q |=> hib_q);
   // R8
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (f1 || af));
endmodule

// File: tb/test_sec_rtc.sv
module test_sec_rtc;
   localparam int unsigned PRESC = 8;
   localparam int unsigned BUSY  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, hib_req;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R1";

   always #4 clk = ~clk;

   sec_rtc #(.ADDR_W(6), .PRESCALE(PRESC), .WR_BUSY(BUSY)) i_sec_rtc (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .hib_req(hib_req));

   // behavioural reference state
   logic [31:0] m_sec, m_alarm, m_scr;
   logic m_f1, m_af, m_ie1, m_aie, m_ae, m_en, m_hib;
   int   m_busy, m_pc;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sec = 0; m_alarm = 0; m_scr = 0;
         m_f1 = 0; m_af = 0; m_ie1 = 0; m_aie = 0; m_ae = 0; m_en = 0; m_hib = 0;
         m_busy = 0; m_pc = 0;
      end else begin
         bit acc, tk, hitv;
         acc  = bus_wr && (m_busy == 0);
         tk   = m_en && (m_pc == PRESC - 1);
         hitv = m_ae && (m_sec == m_alarm);
         if (!m_en) m_pc = 0; else m_pc = (m_pc + 1) % PRESC;
         if (acc) m_busy = BUSY; else if (m_busy > 0) m_busy--;
         if (acc && bus_addr == 6'h04) m_sec = bus_wdata;
         else if (tk) m_sec = m_sec + 1;
         if (acc && bus_addr == 6'h00) begin
            m_f1 = m_f1 & bus_wdata[6];
            m_af = m_af & bus_wdata[4];
            m_ie1 = bus_wdata[5]; m_aie = bus_wdata[3];
            m_ae = bus_wdata[2];  m_en = bus_wdata[0];
         end
         m_f1 = m_f1 | tk;
         m_af = m_af | hitv;
         if (acc && bus_addr == 6'h08) m_alarm = bus_wdata;
         if (acc && bus_addr == 6'h34) m_scr = bus_wdata;
         if (acc && bus_addr == 6'h20 && bus_wdata[0]) m_hib = 1;
      end
   end

   function automatic logic [31:0] model_rd(input logic [5:0] a);
      case (a)
         6'h00: return {24'd0, (m_busy == 0), m_f1, m_ie1, m_af, m_aie, m_ae, 1'b0, m_en};
         6'h04: return m_sec;
         6'h08: return m_alarm;
         6'h20: return {31'd0, m_hib};
         6'h34: return m_scr;
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check({cur_tag, " rdata"}, bus_rdata, model_rd(bus_addr));
      check("R8 irq", {31'd0, irq}, {31'd0, (m_f1 & m_ie1) | (m_af & m_aie)});
      check("R9 hib_req", {31'd0, hib_req}, {31'd0, m_hib});
   endtask

   task automatic step(input logic w, input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      compare_all();
      bus_wr = w; bus_addr = a; bus_wdata = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 6'h00, 32'd0);
   endtask

   task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
      step(1'b0, 6'h00, 32'd0);
      #1;
      while (bus_rdata[7] !== 1'b1) begin
         step(1'b0, 6'h00, 32'd0);
         #1;
      end
      step(1'b1, a, d);
   endtask

   task automatic rd_expect(input string tag, input logic [5:0] a, input logic [31:0] exp);
      step(1'b0, a, 32'd0);
      #1;
      check(tag, bus_rdata, exp);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [31:0] s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_expect("R1 ctrl", 6'h00, 32'h80);
      rd_expect("R1 sec", 6'h04, 32'h0);
      rd_expect("R1 scratch", 6'h34, 32'h0);
      rd_expect("R1 hib", 6'h20, 32'h0);

      // R10 scratchpad, R2 busy window and dropped write
      cur_tag = "R10";
      wr_reg(6'h34, 32'h12345678);
      cur_tag = "R2";
      step(1'b1, 6'h34, 32'hDEADBEEF);
      #1; check("R2 busy", {31'd0, bus_rdata[7]}, 32'd0);
      idle(BUSY + 2);
      rd_expect("R2 ignored", 6'h34, 32'h12345678);
      cur_tag = "R10";
      wr_reg(6'h34, 32'hA5A5_0F0F);
      idle(BUSY);
      rd_expect("R10 scratch", 6'h34, 32'hA5A5_0F0F);

      // R12 read-only and reserved control bits
      cur_tag = "R12";
      wr_reg(6'h00, 32'hFFFF_FF02);
      idle(1);
      rd_expect("R12 reserved", 6'h00, 32'h0000_0050 & 32'h0);
      idle(BUSY);

      // R3 counting, R5 second flag
      cur_tag = "R3";
      wr_reg(6'h00, 32'h01);
      for (int i = 0; i < 3 * PRESC; i++) step(1'b0, 6'h04, 32'd0);
      cur_tag = "R5";
      idle(2);
      rd_expect("R5 flag", 6'h00, 32'h41 | 32'h80);
      // R7 writing one keeps the flag
      cur_tag = "R7";
      wr_reg(6'h00, 32'h40);
      idle(BUSY + 1);
      rd_expect("R7 keep", 6'h00, 32'hC0);
      wr_reg(6'h00, 32'h00);
      idle(BUSY + 1);
      rd_expect("R7 clear", 6'h00, 32'h80);
      // R3 hold while disabled
      cur_tag = "R3";
      step(1'b0, 6'h04, 32'd0); #1; s0 = bus_rdata;
      idle(3 * PRESC);
      rd_expect("R3 hold", 6'h04, s0);

      // R8 second interrupt
      cur_tag = "R8";
      wr_reg(6'h00, 32'h21);
      idle(2 * PRESC + 2);
      wr_reg(6'h00, 32'h01);
      idle(BUSY);

      // R4 load and wrap, R6 alarm
      cur_tag = "R4";
      wr_reg(6'h04, 32'hFFFF_FFFE);
      idle(BUSY);
      rd_expect("R4 load", 6'h04, 32'hFFFF_FFFE);
      cur_tag = "R6";
      wr_reg(6'h08, 32'h0000_0001);
      wr_reg(6'h00, 32'h0D);
      for (int i = 0; i < 4 * PRESC; i++) step(1'b0, 6'h04, 32'd0);
      rd_expect("R6 alarm", 6'h00, {24'd0, 1'b1, m_f1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1});
      cur_tag = "R7";
      wr_reg(6'h00, 32'h09);
      idle(BUSY + 2);
      wr_reg(6'h00, 32'h00);
      idle(BUSY + 2);

      // R9 hibernate
      cur_tag = "R9";
      wr_reg(6'h20, 32'h0);
      idle(BUSY);
      check("R9 idle", {31'd0, hib_req}, 32'd0);
      wr_reg(6'h20, 32'h1);
      idle(1);
      check("R9 set", {31'd0, hib_req}, 32'd1);
      wr_reg(6'h20, 32'h0);
      idle(BUSY);
      rd_expect("R9 sticky", 6'h20, 32'h1);

      // R11 unmapped offsets
      cur_tag = "R11";
      wr_reg(6'h0C, 32'hFFFF_FFFF);
      idle(BUSY);
      rd_expect("R11 regulator", 6'h0C, 32'h0);
      rd_expect("R11 scratch kept", 6'h34, 32'hA5A5_0F0F);
      wr_reg(6'h3C, 32'hFFFF_FFFF);
      idle(BUSY);
      rd_expect("R11 other", 6'h3C, 32'h0);
      rd_expect("R11 ctrl kept", 6'h00, 32'h80);

      idle(4);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule